// File: doc/BRIEF.md
# Snoop-Checked Speculative Load Queue

This block tracks the loads of an out-of-order core so that loads may read memory ahead of older memory operations while the machine still looks sequentially consistent to other processors. Loads take a slot in program order when they are dispatched. When a load executes, it records its address in its slot. Slots leave in order from the head when the reorder logic commits them.

Every coherence snoop that reports another agent writing a line is compared with all slots that have executed and not yet committed. The comparison covers the whole line. Any slot whose line matches is flagged. A flagged load is not allowed to commit. When it reaches the head and commit is requested, the queue raises a flush, names the slot through a restart index, and empties itself. The core then refetches from that load, and every instruction that used the stale value is fetched again as well.

Store handling, data forwarding and the rest of the pipeline sit outside this block.

Top module: `spec_load_queue`

## Requirements
- R1: After reset `alloc_ready` is 1, `alloc_idx` is 0, and `commit_ok` and `flush` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high) takes slot `alloc_idx`. In the next cycle `alloc_idx` is one higher, wrapping from DEPTH-1 to 0.
- R3: When DEPTH slots are in use, `alloc_ready` is 0 and a request on `alloc_valid` is ignored, so `alloc_idx` does not move.
- R4: Suppose `commit_req` is high and the head slot has executed and is not flagged, with no matching snoop in the same cycle. Then `commit_ok` is 1 in that cycle and the slot is freed at the next edge.
- R5: A snoop of kind 1 (write) or kind 2 (upgrade) flags every executed, uncommitted slot whose line matches. When a flagged slot is committed, `flush` is 1, `flush_idx` equals that slot's index and `commit_ok` is 0.
- R6: Lines are compared at cache-line granularity. Addresses that differ only in bits [LINE_OFF-1:0] match. Addresses that differ in any higher bit do not match.
- R7: A snoop that arrives before a slot has executed does not flag that slot.
- R8: A snoop of kind 0 (read) or kind 3 (none) flags nothing.
- R9: If a matching write or upgrade snoop arrives in the same cycle that the head slot is committed, the result is a flush and not a commit.
- R10: A flush empties the queue at the next edge, so `alloc_ready` is 1 and `alloc_idx` is 0 afterwards. During the flush cycle `alloc_ready` is 0 and no allocation is taken.
- R11: A `commit_req` gives neither `commit_ok` nor `flush` when the queue is empty or when the head slot has not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch asks for a slot for the next load |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_idx | output | IDX_W | Slot given to the load being allocated |
| exec_valid | input | 1 | A load has executed speculatively |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Address read by the executed load |
| snoop_valid | input | 1 | A coherence snoop is present |
| snoop_kind | input | 2 | 0 read, 1 write, 2 upgrade, 3 none |
| snoop_addr | input | ADDR_W | Address carried by the snoop |
| commit_req | input | 1 | The head load is at the head of the reorder buffer |
| commit_ok | output | 1 | The head load commits this cycle |
| flush | output | 1 | The head load is flagged: flush and restart at it |
| flush_idx | output | IDX_W | Slot of the load to restart from |

## Verification
The assertions assume that `exec_idx` names a slot that is allocated and has not executed. They also assume that `commit_req` is raised only when the reorder logic has the head load ready. The bench executes only slots it has just allocated. It raises commit only in one-cycle pulses, tracking the head itself. The cases that test R11 raise commit on an empty queue or on an unexecuted head on purpose, and both of those cases are legal. The checker keeps its own occupancy count from the handshakes, so that count is valid only because every allocation the bench makes is observed through `alloc_ready`.

// File: rtl/slq_pkg.sv
package slq_pkg;
   typedef enum logic [1:0] {
      SNP_READ    = 2'd0,
      SNP_WRITE   = 2'd1,
      SNP_UPGRADE = 2'd2,
      SNP_NONE    = 2'd3
   } snoop_kind_e;

   function automatic logic kills_copies(input logic [1:0] kind);
      return (kind == SNP_WRITE) || (kind == SNP_UPGRADE);
   endfunction
endpackage

// File: rtl/slq_ptr.sv
module slq_ptr #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           adv,
   output logic [IDX_W:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/slq_entry.sv
module slq_entry #(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFF = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all,
   input  logic              take,
   input  logic              fill,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              retire,
   input  logic              snp_on,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              busy,
   output logic              done,
   output logic              flagged,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_OFF) - ADDR_W'(1));

   logic [ADDR_W-1:0] addr_q;

   always_comb begin
      hit = busy && done && snp_on && (((addr_q ^ snp_addr) & LINE_MASK) == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         flagged <= 1'b0;
         addr_q  <= '0;
      end else begin
         if (retire) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            flagged <= 1'b0;
         end
         if (take) begin
            busy    <= 1'b1;
            done    <= 1'b0;
            flagged <= 1'b0;
         end
         if (fill && busy) begin
            done   <= 1'b1;
            addr_q <= fill_addr;
         end
         if (hit) begin
            flagged <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue #(
   parameter int DEPTH    = 8,
   parameter int ADDR_W   = 32,
   parameter int LINE_OFF = 6,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_idx,
   input  logic              exec_valid,
   input  logic [IDX_W-1:0]  exec_idx,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic              snoop_valid,
   input  logic [1:0]        snoop_kind,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              commit_req,
   output logic              commit_ok,
   output logic              flush,
   output logic [IDX_W-1:0]  flush_idx
);
   import slq_pkg::*;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spec_load_queue: DEPTH must be a power of two, at least 2");
      end
      if (LINE_OFF < 0 || LINE_OFF >= ADDR_W) begin : g_bad_line
         $error("spec_load_queue: LINE_OFF must lie inside the address");
      end
   endgenerate

   logic [IDX_W:0]     head_p, tail_p;
   logic [IDX_W-1:0]   head_idx;
   logic [DEPTH-1:0]   busy_v, done_v, flag_v, hit_v;
   logic               full, snp_on, head_ready, head_bad, take_new;

   assign head_idx  = head_p[IDX_W-1:0];
   assign alloc_idx = tail_p[IDX_W-1:0];
   assign full      = (head_p[IDX_W] != tail_p[IDX_W]) &&
                      (head_p[IDX_W-1:0] == tail_p[IDX_W-1:0]);
   assign snp_on    = snoop_valid && kills_copies(snoop_kind);

   always_comb begin
      head_ready  = commit_req && busy_v[head_idx] && done_v[head_idx];
      head_bad    = flag_v[head_idx] || hit_v[head_idx];
      flush       = head_ready && head_bad;
      commit_ok   = head_ready && !head_bad;
      flush_idx   = head_idx;
      alloc_ready = !full && !flush;
      take_new    = alloc_valid && alloc_ready;
   end

   slq_ptr #(.DEPTH(DEPTH)) u_head (
      .clk(clk), .rst_n(rst_n), .clr(flush), .adv(commit_ok), .ptr(head_p)
   );

   slq_ptr #(.DEPTH(DEPTH)) u_tail (
      .clk(clk), .rst_n(rst_n), .clr(flush), .adv(take_new), .ptr(tail_p)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         slq_entry #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_all  (flush),
            .take     (take_new && (alloc_idx == IDX_W'(i))),
            .fill     (exec_valid && (exec_idx == IDX_W'(i))),
            .fill_addr(exec_addr),
            .retire   (commit_ok && (head_idx == IDX_W'(i))),
            .snp_on   (snp_on),
            .snp_addr (snoop_addr),
            .busy     (busy_v[i]),
            .done     (done_v[i]),
            .flagged  (flag_v[i]),
            .hit      (hit_v[i])
         );
      end
   endgenerate
endmodule

// File: rtl/slq_checker.sv
module slq_checker #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             alloc_ready,
   input logic [IDX_W-1:0] alloc_idx,
   input logic             commit_req,
   input logic             commit_ok,
   input logic             flush
);
   logic [IDX_W:0] occ;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         occ <= '0;
      end else begin
         occ <= occ + (IDX_W+1)'(alloc_valid && alloc_ready) - (IDX_W+1)'(commit_ok);
      end
   end

   // R3
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == (IDX_W+1)'(DEPTH)) |-> !alloc_ready);

   // R2
   alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready) |=> (alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)));

   // R5
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush && commit_ok));

   // R10
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (alloc_ready && alloc_idx == '0));

   // R11
   empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> (!commit_ok && !flush));

   // R4
   commit_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ok || flush) |-> commit_req);
endmodule

bind spec_load_queue slq_checker #(.DEPTH(DEPTH)) u_slq_chk (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
   .alloc_idx(alloc_idx), .commit_req(commit_req), .commit_ok(commit_ok), .flush(flush)
);

// File: tb/spec_load_queue_bench.sv
`timescale 1ns/1ps
module spec_load_queue_bench;
   localparam int DEPTH  = 8;
   localparam int ADDR_W = 32;
   localparam int IDX_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              alloc_valid, alloc_ready;
   logic [IDX_W-1:0]  alloc_idx;
   logic              exec_valid;
   logic [IDX_W-1:0]  exec_idx;
   logic [ADDR_W-1:0] exec_addr;
   logic              snoop_valid;
   logic [1:0]        snoop_kind;
   logic [ADDR_W-1:0] snoop_addr;
   logic              commit_req, commit_ok, flush;
   logic [IDX_W-1:0]  flush_idx;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 0;
   logic [IDX_W-1:0] exp_tail = '0;

   always #10 clk = ~clk;

   spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_OFF(6)) u_spec_load_queue (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
      .alloc_idx(alloc_idx), .exec_valid(exec_valid), .exec_idx(exec_idx),
      .exec_addr(exec_addr), .snoop_valid(snoop_valid), .snoop_kind(snoop_kind),
      .snoop_addr(snoop_addr), .commit_req(commit_req), .commit_ok(commit_ok),
      .flush(flush), .flush_idx(flush_idx)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      alloc_valid = 0; exec_valid = 0; exec_idx = '0; exec_addr = '0;
      snoop_valid = 0; snoop_kind = 2'd0; snoop_addr = '0; commit_req = 0;
   endtask

   task automatic alloc1(output logic [IDX_W-1:0] idx, input string req);
      alloc_valid = 1;
      #2;
      chk(alloc_ready == 1'b1, req, "alloc_ready", alloc_ready, 1);
      chk(alloc_idx == exp_tail, req, "alloc_idx", alloc_idx, exp_tail);
      idx = alloc_idx;
      step();
      alloc_valid = 0;
      exp_tail = exp_tail + 1'b1;
   endtask

   task automatic exec1(input logic [IDX_W-1:0] idx, input logic [ADDR_W-1:0] a);
      exec_valid = 1; exec_idx = idx; exec_addr = a;
      step();
      exec_valid = 0;
   endtask

   task automatic snoop1(input logic [1:0] kind, input logic [ADDR_W-1:0] a);
      snoop_valid = 1; snoop_kind = kind; snoop_addr = a;
      step();
      snoop_valid = 0;
   endtask

   task automatic commit1(input bit exp_ok, input bit exp_fl,
                          input logic [IDX_W-1:0] exp_fidx, input string req);
      commit_req = 1;
      #2;
      chk(commit_ok == exp_ok, req, "commit_ok", commit_ok, exp_ok);
      chk(flush == exp_fl, req, "flush", flush, exp_fl);
      if (exp_fl) chk(flush_idx == exp_fidx, req, "flush_idx", flush_idx, exp_fidx);
      step();
      commit_req = 0;
      if (exp_fl) exp_tail = '0;
   endtask

   task automatic t_reset();
      chk(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
      chk(alloc_idx == '0, "R1", "alloc_idx", alloc_idx, 0);
      chk(commit_ok == 1'b0, "R1", "commit_ok", commit_ok, 0);
      chk(flush == 1'b0, "R1", "flush", flush, 0);
   endtask

   task automatic t_in_order();
      logic [IDX_W-1:0] s [3];
      for (int i = 0; i < 3; i++) alloc1(s[i], "R2");
      for (int i = 0; i < 3; i++) exec1(s[i], 32'h0000_0100 * (i + 1));
      for (int i = 0; i < 3; i++) commit1(1, 0, '0, "R4");
   endtask

   task automatic t_fill();
      logic [IDX_W-1:0] s [DEPTH];
      for (int i = 0; i < DEPTH; i++) alloc1(s[i], "R2");
      alloc_valid = 1;
      #2;
      chk(alloc_ready == 1'b0, "R3", "alloc_ready when full", alloc_ready, 0);
      step();
      alloc_valid = 0;
      #1;
      chk(alloc_idx == exp_tail, "R3", "alloc_idx after refused alloc", alloc_idx, exp_tail);
      commit1(0, 0, '0, "R11");
      for (int i = 0; i < DEPTH; i++) exec1(s[i], 32'h0001_0000 + 32'(i) * 32'h40);
      for (int i = 0; i < DEPTH; i++) commit1(1, 0, '0, "R4");
   endtask

   task automatic t_line_match();
      logic [IDX_W-1:0] a;
      alloc1(a, "R2");
      exec1(a, 32'h0000_1000);
      snoop1(2'd1, 32'h0000_1004);
      commit1(0, 1, a, "R5");
      chk(alloc_idx == '0, "R10", "alloc_idx after flush", alloc_idx, 0);
      chk(alloc_ready == 1'b1, "R10", "alloc_ready after flush", alloc_ready, 1);
   endtask

   task automatic t_line_miss();
      logic [IDX_W-1:0] a;
      alloc1(a, "R2");
      exec1(a, 32'h0000_2000);
      snoop1(2'd2, 32'h0000_2040);
      commit1(1, 0, '0, "R6");
      alloc1(a, "R2");
      exec1(a, 32'h0000_2000);
      snoop1(2'd0, 32'h0000_2000);
      snoop1(2'd3, 32'h0000_2000);
      commit1(1, 0, '0, "R8");
   endtask

   task automatic t_unexec();
      logic [IDX_W-1:0] a;
      alloc1(a, "R2");
      snoop1(2'd1, 32'h0000_3000);
      exec1(a, 32'h0000_3000);
      commit1(1, 0, '0, "R7");
   endtask

   task automatic t_young_mark();
      logic [IDX_W-1:0] b0, b1;
      alloc1(b0, "R2");
      alloc1(b1, "R2");
      exec1(b0, 32'h0000_4000);
      exec1(b1, 32'h0000_5000);
      snoop1(2'd2, 32'h0000_5008);
      commit1(1, 0, '0, "R5");
      commit1(0, 1, b1, "R5");
   endtask

   task automatic t_same_cycle();
      logic [IDX_W-1:0] a;
      alloc1(a, "R2");
      exec1(a, 32'h0000_6000);
      snoop_valid = 1; snoop_kind = 2'd1; snoop_addr = 32'h0000_6020;
      commit1(0, 1, a, "R9");
      snoop_valid = 0;
   endtask

   task automatic t_flush_alloc();
      logic [IDX_W-1:0] a;
      alloc1(a, "R2");
      exec1(a, 32'h0000_7000);
      snoop1(2'd2, 32'h0000_7010);
      alloc_valid = 1;
      commit_req  = 1;
      #2;
      chk(flush == 1'b1, "R10", "flush", flush, 1);
      chk(alloc_ready == 1'b0, "R10", "alloc_ready during flush", alloc_ready, 0);
      step();
      alloc_valid = 0;
      commit_req  = 0;
      exp_tail    = '0;
      #1;
      chk(alloc_idx == '0, "R10", "alloc_idx after flush", alloc_idx, 0);
      chk(alloc_ready == 1'b1, "R10", "alloc_ready after flush", alloc_ready, 1);
      commit1(0, 0, '0, "R11");
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      #1;
      t_reset();
      t_in_order();
      t_fill();
      t_line_match();
      t_line_miss();
      t_unexec();
      t_young_mark();
      t_same_cycle();
      t_flush_alloc();
      step();
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule